// File: doc/BRIEF.md
# Two-Lane Double-to-Word Saturating Converter

This block turns a 128-bit vector holding two IEEE-754 double-precision values into two 32-bit integers. Each value is truncated toward zero. A mode bit chooses a signed or an unsigned target range. When a value cannot be represented, the block puts a fixed saturation code in its place. Which code is used depends on the mode and on a precedence rule between NaN, negative and too-large inputs.

Each integer result fills both 32-bit words of the 64-bit half that held its source value, so the result keeps the layout of the input. The converter has one register stage behind a plain valid strobe, and `out_valid` follows `in_valid` by one clock. Reset is asserted asynchronously and active low, and is released through a two-flop synchronizer.

Top module: `dp_vec_to_word_sat`

## Requirements
- R1: Each lane is converted on its own, and any fractional part is dropped, so the result rounds toward zero (2.75 gives 2, -2.75 gives 0xFFFFFFFE in signed mode, 0.5 and denormals give 0).
- R2: With `in_unsigned`=0, a non-NaN input above 2147483647.0 (including +infinity) gives 0x7FFFFFFF. A non-NaN input below -2147483648.0 (including -infinity) gives 0x80000000.
- R3: With `in_unsigned`=0, a NaN gives 0x80000000 whatever its sign. A NaN is any pattern whose 11-bit exponent (bits 62:52 of the lane) is all ones and whose 52-bit fraction is nonzero. NaN wins over every other outcome.
- R4: With `in_unsigned`=1, any input whose sign bit (bit 63 of the lane) is set and which is not ±0 gives 0x00000000. This includes -infinity and NaNs with the sign bit set, and the rule wins over the NaN and overflow codes. -0.0 gives 0.
- R5: With `in_unsigned`=1, a NaN with a clear sign bit gives 0x80000000.
- R6: With `in_unsigned`=1, a non-NaN positive input of 4294967296.0 or more (including +infinity) gives 0xFFFFFFFF. 4294967295.0 converts exactly.
- R7: The lane read from `in_data[127:64]` fills both `out_data[127:96]` and `out_data[95:64]`. The lane read from `in_data[63:0]` fills both `out_data[63:32]` and `out_data[31:0]`.
- R8: `out_valid` is high in exactly the cycle after each clock edge at which `in_valid` was high, and `out_data` then holds the converted result.
- R9: While `in_valid` is low, `out_data` keeps its previous value.
- R10: While `rst_n` is low, `out_valid` and `out_data` are zero, and the clear takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_unsigned | input | 1 | 1 selects unsigned conversion, 0 selects signed |
| in_data | input | 128 | Two double-precision lanes, lane 0 in the upper half |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 128 | Two replicated 32-bit results |

## Verification
The clocked properties assume that `in_valid`, `in_unsigned` and `in_data` are known and steady across each rising edge, and that checks only start once the internal synchronized reset has been released. The bench changes inputs only on falling edges. It waits several cycles after releasing reset before it applies any vector. Every input pattern is a fully specified 64-bit encoding, so the NaN, sign and exponent decodes the properties rely on never see unknown bits.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  localparam int FP_W     = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int EXP_BIAS = 1023;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } dp_t;

  typedef enum logic [2:0] {
    SAT_NONE,
    SAT_HIGH,
    SAT_LOW,
    SAT_NAN,
    SAT_NEG
  } sat_kind_e;
endpackage

// File: rtl/dpw_rst_sync.sv
module dpw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/dpw_classify.sv
module dpw_classify
  import dpw_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  dp_t  val,
  output logic is_nan,
  output logic is_zero,
  output logic too_big,
  output logic below_one
);
  // magnitude of 2^INT_W or more can never fit either target range
  localparam logic [EXP_W-1:0] BIG_EXP = EXP_W'(EXP_BIAS + INT_W);
  localparam logic [EXP_W-1:0] ONE_EXP = EXP_W'(EXP_BIAS);

  assign is_nan    = (&val.exp) && (|val.frac);
  assign is_zero   = ~(|val.exp) && ~(|val.frac);
  assign too_big   = (val.exp >= BIG_EXP);
  assign below_one = (val.exp < ONE_EXP);
endmodule

// File: rtl/dpw_trunc.sv
module dpw_trunc
  import dpw_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  dp_t              val,
  input  logic             below_one,
  input  logic             too_big,
  output logic [INT_W-1:0] mag
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int SH_W   = $clog2(MANT_W + 1);

  logic [MANT_W-1:0] mant;
  logic [MANT_W-1:0] shifted;
  logic [EXP_W-1:0]  unbiased;
  logic [SH_W-1:0]   rsh;

  always_comb begin
    mant     = {1'b1, val.frac};
    unbiased = val.exp - EXP_W'(EXP_BIAS);
    if (below_one || too_big) begin
      rsh     = '0;
      shifted = '0;
    end else begin
      // integer part: drop the fraction bits below the binary point
      rsh     = SH_W'(FRAC_W) - SH_W'(unbiased);
      shifted = mant >> rsh;
    end
    mag = shifted[INT_W-1:0];
  end
endmodule

// File: rtl/dpw_lane.sv
module dpw_lane
  import dpw_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  dp_t              val,
  input  logic             unsigned_mode,
  output logic [INT_W-1:0] word
);
  localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] UMAX = '1;

  logic             is_nan;
  logic             is_zero;
  logic             too_big;
  logic             below_one;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] trunc_res;
  logic [INT_W-1:0] code;
  logic [INT_W-1:0] err_mask;
  sat_kind_e        kind;

  dpw_classify #(.INT_W(INT_W)) u_class (
    .val       (val),
    .is_nan    (is_nan),
    .is_zero   (is_zero),
    .too_big   (too_big),
    .below_one (below_one)
  );

  dpw_trunc #(.INT_W(INT_W)) u_trunc (
    .val       (val),
    .below_one (below_one),
    .too_big   (too_big),
    .mag       (mag)
  );

  always_comb begin
    kind = SAT_NONE;
    if (unsigned_mode) begin
      // strictly negative outranks NaN and overflow here
      if (val.sign && !is_zero)  kind = SAT_NEG;
      else if (is_nan)           kind = SAT_NAN;
      else if (too_big)          kind = SAT_HIGH;
    end else begin
      if (is_nan)                                     kind = SAT_NAN;
      else if (!val.sign && (too_big || mag > SMAX))  kind = SAT_HIGH;
      else if (val.sign && (too_big || mag > SMIN))   kind = SAT_LOW;
    end

    unique case (kind)
      SAT_HIGH: code = unsigned_mode ? UMAX : SMAX;
      SAT_LOW:  code = SMIN;
      SAT_NAN:  code = SMIN;
      SAT_NEG:  code = '0;
      default:  code = '0;
    endcase

    err_mask  = (kind != SAT_NONE) ? '1 : '0;
    trunc_res = (!unsigned_mode && val.sign) ? (~mag + 1'b1) : mag;
    word      = (trunc_res & ~err_mask) | (code & err_mask);
  end
endmodule

// File: rtl/dp_vec_to_word_sat.sv
module dp_vec_to_word_sat
  import dpw_pkg::*;
#(
  parameter int LANES = 2,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_unsigned,
  input  logic [LANES*FP_W-1:0]  in_data,
  output logic                   out_valid,
  output logic [LANES*FP_W-1:0]  out_data
);
  localparam int DW  = LANES * FP_W;
  localparam int REP = FP_W / INT_W;
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] BIG_EXP = EXP_W'(EXP_BIAS + INT_W);

  logic             rst_sync_n;
  dp_t              lane_val  [LANES];
  logic [INT_W-1:0] lane_word [LANES];
  logic [DW-1:0]    res_next;
  logic             valid_d;
  logic             valid_q;
  logic [DW-1:0]    data_d;
  logic [DW-1:0]    data_q;

  dpw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int TOP = DW - 1 - g * FP_W;

    assign lane_val[g] = dp_t'(in_data[TOP -: FP_W]);

    dpw_lane #(.INT_W(INT_W)) u_lane (
      .val           (lane_val[g]),
      .unsigned_mode (in_unsigned),
      .word          (lane_word[g])
    );

    assign res_next[TOP -: FP_W] = {REP{lane_word[g]}};

    // R3
    sgn_nan_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && !in_unsigned && (&lane_val[g].exp) && (|lane_val[g].frac))
      |=> out_data[TOP -: INT_W] == SMIN);

    // R4
    uns_neg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && in_unsigned && lane_val[g].sign &&
       ((|lane_val[g].exp) || (|lane_val[g].frac)))
      |=> out_data[TOP -: INT_W] == '0);

    // R6
    uns_ovf_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && in_unsigned && !lane_val[g].sign &&
       (lane_val[g].exp >= BIG_EXP) && !((&lane_val[g].exp) && (|lane_val[g].frac)))
      |=> out_data[TOP -: INT_W] == '1);
  end

  // next-state
  always_comb begin
    valid_d = in_valid;
    data_d  = in_valid ? res_next : data_q;
  end

  // register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        data_q <= data_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_data));
endmodule

// File: tb/tb_dp_vec_to_word_sat.sv
module tb_dp_vec_to_word_sat;
  localparam int PERIOD = 10;
  localparam int NV     = 16;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_unsigned;
  logic [127:0] in_data;
  logic         out_valid;
  logic [127:0] out_data;

  int checks;
  int fails;

  // {mode, lane0, lane1, expect0, expect1}
  localparam logic [192:0] VECS [NV] = '{
    {1'b0, 64'h3FF0000000000000, 64'hC006000000000000, 32'h00000001, 32'hFFFFFFFE},
    {1'b0, 64'h4006000000000000, 64'h3FE0000000000000, 32'h00000002, 32'h00000000},
    {1'b0, 64'hC0FE240000000000, 64'h0000000000000001, 32'hFFFE1DC0, 32'h00000000},
    {1'b0, 64'h41DFFFFFFFC00000, 64'h41E0000000000000, 32'h7FFFFFFF, 32'h7FFFFFFF},
    {1'b0, 64'hC1E0000000000000, 64'hC1E0000000200000, 32'h80000000, 32'h80000000},
    {1'b0, 64'h7FF0000000000000, 64'hFFF0000000000000, 32'h7FFFFFFF, 32'h80000000},
    {1'b0, 64'h7FF8000000000000, 64'hFFF8000000000000, 32'h80000000, 32'h80000000},
    {1'b0, 64'h7FF0000000000001, 64'h41F0000000000000, 32'h80000000, 32'h7FFFFFFF},
    {1'b1, 64'h41E65A0BC0000000, 64'h4006000000000000, 32'hB2D05E00, 32'h00000002},
    {1'b1, 64'h41EFFFFFFFE00000, 64'h41F0000000000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b1, 64'h7FF0000000000000, 64'hBFF0000000000000, 32'hFFFFFFFF, 32'h00000000},
    {1'b1, 64'h8000000000000000, 64'hBFE0000000000000, 32'h00000000, 32'h00000000},
    {1'b1, 64'hFFF8000000000000, 64'hFFF0000000000000, 32'h00000000, 32'h00000000},
    {1'b1, 64'h7FF8000000000000, 64'h7FF0000000000001, 32'h80000000, 32'h80000000},
    {1'b0, 64'h8000000000000000, 64'hBFF0000000000000, 32'h00000000, 32'hFFFFFFFF},
    {1'b1, 64'h41E0000000000000, 64'h3FE0000000000000, 32'h80000000, 32'h00000000}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 2, 8: return "R1";
      3, 4, 5:    return "R2";
      6, 7:       return "R3";
      9:          return "R6";
      10:         return "R6 R4";
      11, 12:     return "R4";
      13:         return "R5";
      default:    return "R1";
    endcase
  endfunction

  dp_vec_to_word_sat dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_unsigned (in_unsigned),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_data    (out_data)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] held;
    checks      = 0;
    fails       = 0;
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_unsigned = 1'b0;
    in_data     = '0;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid in reset", {127'd0, out_valid}, 128'd0);
    check("R10 data in reset", out_data, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idle valid after reset", {127'd0, out_valid}, 128'd0);

    for (int i = 0; i < NV; i++) begin
      logic [192:0] v;
      v = VECS[i];
      in_valid    = 1'b1;
      in_unsigned = v[192];
      in_data     = v[191:64];
      @(negedge clk);
      in_valid = 1'b0;
      check({"R7 R8 ", row_tag(i), " valid"}, {127'd0, out_valid}, 128'd1);
      check({"R7 ", row_tag(i), " data"}, out_data,
            {v[63:32], v[63:32], v[31:0], v[31:0]});
    end

    // R8 valid drops one cycle after the strobe
    @(negedge clk);
    check("R8 valid falls", {127'd0, out_valid}, 128'd0);

    // R9 data held while strobe low, inputs wiggling
    held = out_data;
    in_unsigned = 1'b1;
    for (int k = 0; k < 3; k++) begin
      in_data = {64'h3FF0000000000000, 64'h4006000000000000} ^ {k[63:0], 64'd0};
      @(negedge clk);
      check("R9 hold data", out_data, held);
      check("R9 hold valid", {127'd0, out_valid}, 128'd0);
    end

    // R8 back-to-back strobes
    in_valid    = 1'b1;
    in_unsigned = 1'b0;
    in_data     = {64'h3FF0000000000000, 64'h4006000000000000};
    @(negedge clk);
    in_data     = {64'hC006000000000000, 64'h3FF0000000000000};
    check("R8 back-to-back first", out_data,
          {32'h1, 32'h1, 32'h2, 32'h2});
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 back-to-back second", out_data,
          {32'hFFFFFFFE, 32'hFFFFFFFE, 32'h1, 32'h1});
    check("R8 back-to-back valid", {127'd0, out_valid}, 128'd1);

    // R10 asynchronous clear mid-cycle
    in_valid = 1'b1;
    @(negedge clk);
    #(PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R10 async valid clear", {127'd0, out_valid}, 128'd0);
    check("R10 async data clear", out_data, 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule